// File: doc/BRIEF.md
# Single-Wire Output-Voltage Programming Receiver

This block sits behind a shared mode/data pin of a dual step-down converter controller. A host sends a timed serial frame on the pin: an 8-bit device address, then an 8-bit data byte, both most significant bit first. Each bit starts with a falling edge and has a low phase and a high phase. The block measures both phases in clock cycles. When the frame is complete and the address matches, the block stores a 5-bit voltage code into one of three code registers. If the host asks for it, the block also pulls the line low for a fixed time as an acknowledge.

The same pin selects the converter operating mode. Forced PWM is reported whenever the pin is high and for the whole of a frame. Power-save is reported only once the pin has been low for a programmable number of cycles. Because of this, a falling edge meant as a mode change already counts as the start of bit 0. A frame sent before that low period times out is therefore received one bit out of step and is rejected.

A level-select input chooses which of the two converter-1 code registers drives the active converter-1 code.

Top module: `swire_vprog_rx`

## Requirements
- R1: `pwm_force_o` is 1 in the same cycle that `pin_i` is 1, with no clock edge needed. It stays 1 during every phase of a frame whose low phases are shorter than `TIMEOUT_CYC`.
- R2: If `pin_i` is sampled low on `TIMEOUT_CYC` consecutive rising edges, `pwm_force_o` becomes 0 after the last of those edges. It stays 0 until `pin_i` is high again. After reset `pwm_force_o` is 1.
- R3: A bit runs from one falling edge of `pin_i` to the next. Its value is 1 only if the count of high cycles exceeds the count of low cycles, so a tie decodes as 0. Both counts saturate at 2^`CNT_W`-1, so a high phase longer than the counter range still decodes as 1.
- R4: A frame is 16 bits, most significant bit first, and completes at the 17th falling edge. The first 8 bits must equal `DEV_ADDR` (default 0x4E). Any other address leaves all code registers unchanged and gives no acknowledge.
- R5: Data byte layout. Bit 7 requests an acknowledge. Bits 6:5 pick the target: 0 is the converter-1 low-select register, 1 is the converter-1 high-select register, 2 is the converter-2 register, and 3 is reserved and writes nothing. Bits 4:0 are the code. The register output shows the new code one clock after the completing falling edge is sampled.
- R6: After a matching frame with bit 7 set, `ack_pull_o` is 1 for exactly `ACK_CYC` cycles, starting the cycle after the completing edge. In every other case it stays 0. The block only ever requests a pull-down.
- R7: If the line stays low for `TIMEOUT_CYC` cycles in the middle of a frame, the frame is abandoned with no write. The next complete frame is decoded normally.
- R8: A frame that begins while the line is still in a low period started by an earlier falling edge, before the timeout, is received shifted by one bit. For address 0x4E it is rejected and leaves every register unchanged.
- R9: `c1_act_o` equals `c1_hi_o` when `lvl_sel_i` is 1 and `c1_lo_o` when it is 0, with no clock edge needed.
- R10: Reset loads `RST_C1_LO`, `RST_C1_HI` and `RST_C2` (defaults 16, 30, 31) into the three code registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Synchronised level of the shared mode/data line |
| lvl_sel_i | input | 1 | Chooses the converter-1 high-select register when 1 |
| c1_lo_o | output | 5 | Converter-1 code used with level select low |
| c1_hi_o | output | 5 | Converter-1 code used with level select high |
| c2_o | output | 5 | Converter-2 code |
| c1_act_o | output | 5 | Converter-1 code currently selected by `lvl_sel_i` |
| pwm_force_o | output | 1 | 1 = forced PWM, 0 = power-save allowed |
| ack_pull_o | output | 1 | Enable for the open-drain pull-down on the line |

## Verification
The bench builds the block with `TIMEOUT_CYC` = 64, `ACK_CYC` = 6 and `CNT_W` = 6. A 64-cycle timeout lets power-save entry, abandoned frames and misaligned frames each be exercised in a few hundred cycles. A 6-bit phase counter saturates at 63, so a single 150-cycle high phase already reaches the saturation corner while every low phase stays below the timeout. The short acknowledge lets the bench count the exact pull-down length after each frame.

// File: rtl/swv_pkg.sv
package swv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RX   = 2'd1,
        ST_ACK  = 2'd2
    } rx_state_e;

    localparam int unsigned FRAME_BITS = 16;
    localparam int unsigned CODE_W     = 5;
    localparam int unsigned NUM_SLOTS  = 3;
endpackage

// File: rtl/swv_bit_meter.sv
module swv_bit_meter #(
    parameter int unsigned CNT_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic pin_i,
    output logic bit_o
);
    typedef struct packed {
        logic [CNT_W-1:0] lo;
        logic [CNT_W-1:0] hi;
    } meter_t;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    meter_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (restart_i) begin
            m_d.lo = CNT_W'(1);
            m_d.hi = '0;
        end else if (pin_i) begin
            if (m_q.hi != CNT_MAX) m_d.hi = m_q.hi + 1'b1;
        end else begin
            if (m_q.lo != CNT_MAX) m_d.lo = m_q.lo + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    // strictly longer high phase decodes as one; ties fall to zero
    assign bit_o = (m_q.hi > m_q.lo);
endmodule

// File: rtl/swv_low_timer.sv
module swv_low_timer #(
    parameter int unsigned TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic expired_o
);
    localparam int unsigned RUN_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [RUN_W-1:0] LIMIT = RUN_W'(TIMEOUT_CYC - 1);

    logic [RUN_W-1:0] run_d, run_q;

    always_comb begin
        if (pin_i)              run_d = '0;
        else if (run_q < LIMIT) run_d = run_q + 1'b1;
        else                    run_d = run_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign expired_o = !pin_i && (run_q >= LIMIT);
endmodule

// File: rtl/swv_reg_bank.sv
module swv_reg_bank
    import swv_pkg::*;
#(
    parameter int unsigned RST_C1_LO = 16,
    parameter int unsigned RST_C1_HI = 30,
    parameter int unsigned RST_C2    = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [1:0]        sel_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] c1_lo_o,
    output logic [CODE_W-1:0] c1_hi_o,
    output logic [CODE_W-1:0] c2_o
);
    localparam logic [NUM_SLOTS-1:0][CODE_W-1:0] RST_VALS = {
        CODE_W'(RST_C2), CODE_W'(RST_C1_HI), CODE_W'(RST_C1_LO)
    };

    logic [NUM_SLOTS-1:0][CODE_W-1:0] slot_d, slot_q;

    // select value 3 matches no slot and so writes nothing
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (we_i && (sel_i == 2'(g))) slot_d[g] = code_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= RST_VALS[g];
            else        slot_q[g] <= slot_d[g];
        end
    end

    assign c1_lo_o = slot_q[0];
    assign c1_hi_o = slot_q[1];
    assign c2_o    = slot_q[2];
endmodule

// File: rtl/swire_vprog_rx.sv
module swire_vprog_rx
    import swv_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 1000,
    parameter int unsigned ACK_CYC     = 64,
    parameter int unsigned CNT_W       = 10,
    parameter logic [7:0]  DEV_ADDR    = 8'h4E,
    parameter int unsigned RST_C1_LO   = 16,
    parameter int unsigned RST_C1_HI   = 30,
    parameter int unsigned RST_C2      = 31
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic       lvl_sel_i,
    output logic [4:0] c1_lo_o,
    output logic [4:0] c1_hi_o,
    output logic [4:0] c2_o,
    output logic [4:0] c1_act_o,
    output logic       pwm_force_o,
    output logic       ack_pull_o
);
    localparam int unsigned NB_W  = $clog2(FRAME_BITS + 1);
    localparam int unsigned ACK_W = $clog2(ACK_CYC);
    localparam logic [NB_W-1:0]  LAST_IDX = NB_W'(FRAME_BITS - 1);
    localparam logic [ACK_W-1:0] ACK_LAST = ACK_W'(ACK_CYC - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [FRAME_BITS-2:0] sh;
        logic [NB_W-1:0]   nbits;
        logic [ACK_W-1:0]  ack_cnt;
        logic              pin_prev;
        logic              ps;
    } core_t;

    core_t c_d, c_q;

    logic fall;
    logic bit_val;
    logic tmo;
    logic we;
    logic [FRAME_BITS-1:0] word;

    assign fall = c_q.pin_prev & ~pin_i;
    assign word = {c_q.sh, bit_val};

    swv_bit_meter #(.CNT_W(CNT_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (fall),
        .pin_i     (pin_i),
        .bit_o     (bit_val)
    );

    swv_low_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .expired_o (tmo)
    );

    always_comb begin
        c_d          = c_q;
        c_d.pin_prev = pin_i;
        we           = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (fall) begin
                    c_d.st    = ST_RX;
                    c_d.nbits = '0;
                end
            end
            ST_RX: begin
                if (tmo) begin
                    c_d.st = ST_IDLE;
                end else if (fall) begin
                    c_d.sh    = word[FRAME_BITS-2:0];
                    c_d.nbits = c_q.nbits + 1'b1;
                    if (c_q.nbits == LAST_IDX) begin
                        c_d.nbits = '0;
                        c_d.st    = ST_IDLE;
                        if (word[15:8] == DEV_ADDR) begin
                            we = 1'b1;
                            if (word[7]) begin
                                c_d.st      = ST_ACK;
                                c_d.ack_cnt = '0;
                            end
                        end
                    end
                end
            end
            ST_ACK: begin
                if (c_q.ack_cnt == ACK_LAST) c_d.st = ST_IDLE;
                else                         c_d.ack_cnt = c_q.ack_cnt + 1'b1;
            end
            default: c_d.st = ST_IDLE;
        endcase
        if (pin_i)                           c_d.ps = 1'b0;
        else if (tmo && (c_q.st != ST_ACK))  c_d.ps = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    swv_reg_bank #(
        .RST_C1_LO (RST_C1_LO),
        .RST_C1_HI (RST_C1_HI),
        .RST_C2    (RST_C2)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .sel_i   (word[6:5]),
        .code_i  (word[4:0]),
        .c1_lo_o (c1_lo_o),
        .c1_hi_o (c1_hi_o),
        .c2_o    (c2_o)
    );

    assign c1_act_o    = lvl_sel_i ? c1_hi_o : c1_lo_o;
    assign pwm_force_o = pin_i | ~c_q.ps;
    assign ack_pull_o  = (c_q.st == ST_ACK);
endmodule

// File: rtl/swv_rx_checker.sv
module swv_rx_checker #(
    parameter int unsigned TIMEOUT_CYC = 1000,
    parameter int unsigned ACK_CYC     = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pin_i,
    input logic       pwm_force_o,
    input logic       ack_pull_o,
    input logic [4:0] c1_lo_o,
    input logic [4:0] c1_hi_o,
    input logic [4:0] c2_o
);
    localparam int unsigned LW = $clog2(TIMEOUT_CYC + 1);
    localparam int unsigned AW = $clog2(ACK_CYC + 2);
    localparam logic [LW-1:0] LOW_SAT = LW'(TIMEOUT_CYC);
    localparam logic [AW-1:0] ACK_SAT = AW'(ACK_CYC + 1);

    logic          pin_q;
    logic [LW-1:0] low_run;
    logic [AW-1:0] ack_run;
    logic          fall_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q   <= 1'b0;
            low_run <= '0;
            ack_run <= '0;
        end else begin
            pin_q <= pin_i;
            if (pin_i)                  low_run <= '0;
            else if (low_run < LOW_SAT) low_run <= low_run + 1'b1;
            if (!ack_pull_o)            ack_run <= '0;
            else if (ack_run < ACK_SAT) ack_run <= ack_run + 1'b1;
        end
    end

    assign fall_c = pin_q & ~pin_i;

    // R1
    pwm_when_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_i |-> pwm_force_o);

    // R2
    ps_needs_long_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_force_o |-> (low_run == LOW_SAT));

    // R6
    ack_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_run <= AW'(ACK_CYC));

    // R6
    ack_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_pull_o) |-> $past(fall_c));

    // R5
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_c |=> ($stable(c1_lo_o) && $stable(c1_hi_o) && $stable(c2_o)));
endmodule

bind swire_vprog_rx swv_rx_checker #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .ACK_CYC     (ACK_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin_i),
    .pwm_force_o (pwm_force_o),
    .ack_pull_o  (ack_pull_o),
    .c1_lo_o     (c1_lo_o),
    .c1_hi_o     (c1_hi_o),
    .c2_o        (c2_o)
);

// File: tb/sim_swire_vprog_rx.sv
`timescale 1ns/1ps
module sim_swire_vprog_rx;
    localparam int TMO  = 64;
    localparam int ACKC = 6;
    localparam int CW   = 6;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_drv;
    logic       lvl_sel;
    logic       line;
    logic [4:0] c1_lo, c1_hi, c2, c1_act;
    logic       pwm, ack_pull;

    int n_chk = 0;
    int n_err = 0;
    int exp_lo, exp_hi, exp_c2;

    always #2 clk = ~clk;

    // open-drain line: host drives or releases, block can only pull low
    assign line = host_drv & ~ack_pull;

    swire_vprog_rx #(
        .TIMEOUT_CYC (TMO),
        .ACK_CYC     (ACKC),
        .CNT_W       (CW)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (line),
        .lvl_sel_i   (lvl_sel),
        .c1_lo_o     (c1_lo),
        .c1_hi_o     (c1_hi),
        .c2_o        (c2),
        .c1_act_o    (c1_act),
        .pwm_force_o (pwm),
        .ack_pull_o  (ack_pull)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic int sat(input int v);
        return (v > (1 << CW) - 1) ? (1 << CW) - 1 : v;
    endfunction

    function automatic bit exp_bit(input int lo, input int hi);
        return sat(hi) > sat(lo);
    endfunction

    task automatic check_regs(input string req);
        chk({req, " c1_lo"}, c1_lo, exp_lo);
        chk({req, " c1_hi"}, c1_hi, exp_hi);
        chk({req, " c2"}, c2, exp_c2);
    endtask

    function automatic void model_frame(input logic [7:0] addr, input logic [7:0] data);
        if (addr == 8'h4E) begin
            case (data[6:5])
                2'd0: exp_lo = data[4:0];
                2'd1: exp_hi = data[4:0];
                2'd2: exp_c2 = data[4:0];
                default: ;
            endcase
        end
    endfunction

    // sends one frame; long_idx / tie_idx select bits with special phase lengths
    task automatic send_frame(input logic [7:0] addr, input logic [7:0] data,
                              input int exp_ack, input int long_idx, input int tie_idx,
                              input string req);
        logic [15:0] w;
        int lo, hi, s, l, cnt;
        w = {addr, data};
        for (int i = 15; i >= 0; i--) begin
            s = $urandom_range(2, 5);
            l = $urandom_range(8, 16);
            if (i == long_idx)      begin lo = 3; hi = 150; end
            else if (i == tie_idx)  begin lo = 5; hi = 5;   end
            else if (w[i])          begin lo = s; hi = l;   end
            else                    begin lo = l; hi = s;   end
            if (exp_bit(lo, hi) != w[i]) $display("bench bit setup mismatch at %0d", i);
            host_drv = 1'b0;
            tick(lo);
            if (i == 8) chk("R1 pwm during frame low phase", pwm, 1);
            host_drv = 1'b1;
            tick(hi);
        end
        host_drv = 1'b0;
        tick(1);
        cnt = 0;
        for (int k = 0; k < ACKC + 4; k++) begin
            if (ack_pull) cnt++;
            tick(1);
        end
        chk({req, " R6 ack cycles"}, cnt, exp_ack);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R1 actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] a, d;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; host_drv = 1'b0; lvl_sel = 1'b0;
        exp_lo = 16; exp_hi = 30; exp_c2 = 31;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check_regs("R10 reset");
        chk("R2 pwm after reset", pwm, 1);
        chk("R6 no ack after reset", ack_pull, 0);

        // R1: immediate forced PWM on high; R2: exact timeout
        host_drv = 1'b1; tick(5);
        host_drv = 1'b0;
        tick(TMO - 1);
        chk("R2 pwm before timeout", pwm, 1);
        tick(1);
        chk("R2 power-save after timeout", pwm, 0);
        tick(10);
        chk("R2 power-save held", pwm, 0);
        host_drv = 1'b1; #1;
        chk("R1 pwm at once on high", pwm, 1);
        tick(4);

        // R4 R5 R6: directed write with ack, saturating high phase, tie bit
        send_frame(8'h4E, {1'b1, 2'd2, 5'd9}, ACKC, 14, 4, "R3 saturate/tie");
        model_frame(8'h4E, {1'b1, 2'd2, 5'd9});
        check_regs("R3 R5 sat/tie frame");

        // R5: reserved target
        host_drv = 1'b1; tick(4);
        send_frame(8'h4E, {1'b1, 2'd3, 5'd1}, ACKC, -1, -1, "R5 reserved");
        check_regs("R5 reserved target");

        // R4: wrong address
        host_drv = 1'b1; tick(4);
        send_frame(8'h4F, {1'b1, 2'd0, 5'd3}, 0, -1, -1, "R4 bad addr");
        check_regs("R4 bad address");

        // R9: level select chooses converter-1 register
        host_drv = 1'b1; tick(4);
        send_frame(8'h4E, {1'b0, 2'd0, 5'd4}, 0, -1, -1, "R5 c1 lo");
        model_frame(8'h4E, {1'b0, 2'd0, 5'd4});
        lvl_sel = 1'b0; #1;
        chk("R9 active code lo", c1_act, exp_lo);
        lvl_sel = 1'b1; #1;
        chk("R9 active code hi", c1_act, exp_hi);

        // R7: abort mid-frame by timeout, then recover
        host_drv = 1'b1; tick(4);
        for (int i = 7; i >= 0; i--) begin
            host_drv = 1'b0; tick((8'h4E >> i) & 1 ? 3 : 10);
            host_drv = 1'b1; tick((8'h4E >> i) & 1 ? 10 : 3);
        end
        host_drv = 1'b0; tick(TMO + 3);
        chk("R7 power-save after abort", pwm, 0);
        check_regs("R7 abort no write");
        host_drv = 1'b1; tick(4);
        send_frame(8'h4E, {1'b0, 2'd1, 5'd0}, 0, -1, -1, "R7 recover");
        model_frame(8'h4E, {1'b0, 2'd1, 5'd0});
        check_regs("R7 recovered frame");

        // R8: frame sent inside a pending low period is misaligned
        host_drv = 1'b1; tick(5);
        host_drv = 1'b0; tick(20);
        host_drv = 1'b1; tick(3);
        send_frame(8'h4E, {1'b1, 2'd2, 5'd7}, 0, -1, -1, "R8 misaligned");
        check_regs("R8 misaligned frame");
        tick(TMO);

        // random frames
        for (int n = 0; n < 40; n++) begin
            a = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 255)) : 8'h4E;
            d = 8'($urandom_range(0, 255));
            host_drv = 1'b1; tick($urandom_range(2, 8));
            send_frame(a, d, (a == 8'h4E && d[7]) ? ACKC : 0, -1, -1, "R4 R5 random");
            model_frame(a, d);
            check_regs("R5 random frame");
            if (n % 8 == 7) begin
                tick(TMO);
                chk("R2 power-save after frame", pwm, 0);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule